// File: doc/BRIEF.md
# Three-Player Quiz Buzzer Arbiter

This block arbitrates the answer turn in a quiz game with three contestants. Every clock cycle it samples an encoded buzz code that names the contestant who pressed, a "wrong" verdict and a "correct" verdict from the host, and a synchronous reset. When nobody holds the floor, it grants the turn to the contestant who buzzed, provided that contestant has not already answered wrongly. While someone holds the floor, a wrong verdict bars that contestant and hands the floor back. A correct verdict ends the question and clears everything.

Contestants who answer wrongly stay barred until the question ends. If all three become barred, the block holds still until reset. The five state bits are exposed directly, and there is one lamp output per contestant. Buttons are synchronised upstream, and simultaneous presses are merged into a single code upstream.

Top module: `quiz_arbiter`

## Requirements
- R1: `state_o` is five bits. Bit 4 is the bar flag of contestant 1, bit 3 is the bar flag of contestant 2 and bit 2 is the bar flag of contestant 3; a flag of 1 means barred. Bits 1:0 hold the current answerer: 01 is contestant 1, 10 is contestant 2, 11 is contestant 3 and 00 is nobody.
- R2: A high `rst` at a clock edge sets `state_o` to 00000, whatever the state and the other inputs.
- R3: With no answerer, a `buzz` code of 01, 10 or 11 from a contestant whose bar flag is 0 loads that code into bits 1:0 at the next edge.
- R4: With no answerer, a buzz from a barred contestant, or the code 00, leaves the state unchanged.
- R5: While a contestant answers, `buzz` is ignored, and the state holds if neither verdict is given.
- R6: While a contestant answers, `wrong` sets that contestant's bar flag and clears bits 1:0 to 00. `wrong` takes priority over `correct`.
- R7: While a contestant answers, `correct` without `wrong` returns the state to 00000.
- R8: With no answerer, `wrong` and `correct` have no effect.
- R9: When all three bar flags are set (state 11100), the state holds until reset.
- R10: `lamp[0]`, `lamp[1]` and `lamp[2]` belong to contestants 1, 2 and 3. Exactly the lamp of the answerer named in bits 1:0 is lit, and no lamp is lit when the code is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, highest priority |
| buzz | input | 2 | Encoded contestant press, 00 means no press |
| wrong | input | 1 | Host verdict: the current answer is wrong |
| correct | input | 1 | Host verdict: the current answer is right |
| state_o | output | 5 | Bar flags of contestants 1..3 followed by the answerer code |
| lamp | output | 3 | One lamp per contestant, lit for the answerer |

## Verification
The hardest state to reach from the ports is the fully barred state 11100. To get there, three separate grant-then-wrong rounds must complete with no correct verdict and no reset in between, and the random stimulus alone does this only rarely. The bench therefore drives a directed sequence that walks through all three lockouts. In that state it tries every buzz code and both verdicts. The random phase keeps resets and correct verdicts rare, so that partly barred states with a refused buzz also come up often.

// File: rtl/quiz_pkg.sv
package quiz_pkg;
  localparam int unsigned NPLAYER = 3;
  localparam int unsigned ID_W    = $clog2(NPLAYER + 1);
  localparam int unsigned STATE_W = NPLAYER + ID_W;

  typedef logic [ID_W-1:0]    pid_t;
  typedef logic [NPLAYER-1:0] pmask_t;

  localparam pid_t NOBODY = '0;

  // One-hot mask for a contestant number; bit i stands for contestant i+1.
  function automatic pmask_t pid_to_mask(pid_t id);
    pmask_t m;
    m = '0;
    for (int i = 0; i < NPLAYER; i++) begin
      if (id == pid_t'(i + 1)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic is_barred(pmask_t lk, pid_t id);
    return |(lk & pid_to_mask(id));
  endfunction
endpackage

// File: rtl/quiz_judge.sv
module quiz_judge
  import quiz_pkg::*;
(
  input  logic   rst,
  input  pid_t   buzz,
  input  logic   wrong,
  input  logic   correct,
  input  pmask_t lock,
  input  pid_t   turn,
  output logic   ev_grant,
  output logic   ev_fault,
  output logic   ev_win
);
  logic busy;

  always_comb begin
    busy     = (turn != NOBODY);
    ev_fault = !rst && busy && wrong;
    ev_win   = !rst && busy && !wrong && correct;
    ev_grant = !rst && !busy && (buzz != NOBODY) && !is_barred(lock, buzz);
  end
endmodule

// File: rtl/quiz_lock_reg.sv
module quiz_lock_reg
  import quiz_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ev_fault,
  input  logic   ev_win,
  input  pid_t   turn,
  output pmask_t lock
);
  always_ff @(posedge clk) begin
    if (rst || ev_win)  lock <= '0;
    else if (ev_fault)  lock <= lock | pid_to_mask(turn);
  end
endmodule

// File: rtl/quiz_turn_reg.sv
module quiz_turn_reg
  import quiz_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ev_grant,
  input  logic ev_fault,
  input  logic ev_win,
  input  pid_t buzz,
  output pid_t turn
);
  always_ff @(posedge clk) begin
    if (rst || ev_win || ev_fault) turn <= NOBODY;
    else if (ev_grant)             turn <= buzz;
  end
endmodule

// File: rtl/quiz_lamp_dec.sv
module quiz_lamp_dec
  import quiz_pkg::*;
(
  input  pid_t   turn,
  output pmask_t lamp
);
  for (genvar g = 0; g < NPLAYER; g++) begin : g_lamp
    assign lamp[g] = (turn == pid_t'(g + 1));
  end
endmodule

// File: rtl/quiz_arbiter.sv
module quiz_arbiter
  import quiz_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [ID_W-1:0]    buzz,
  input  logic               wrong,
  input  logic               correct,
  output logic [STATE_W-1:0] state_o,
  output logic [NPLAYER-1:0] lamp
);
  pmask_t lock;
  pid_t   turn;
  logic   ev_grant;
  logic   ev_fault;
  logic   ev_win;

  quiz_judge u_judge (
    .rst(rst), .buzz(buzz), .wrong(wrong), .correct(correct),
    .lock(lock), .turn(turn),
    .ev_grant(ev_grant), .ev_fault(ev_fault), .ev_win(ev_win)
  );

  quiz_lock_reg u_lock (
    .clk(clk), .rst(rst), .ev_fault(ev_fault), .ev_win(ev_win),
    .turn(turn), .lock(lock)
  );

  quiz_turn_reg u_turn (
    .clk(clk), .rst(rst), .ev_grant(ev_grant), .ev_fault(ev_fault),
    .ev_win(ev_win), .buzz(buzz), .turn(turn)
  );

  quiz_lamp_dec u_lamp (
    .turn(turn), .lamp(lamp)
  );

  // Contestant 1's flag sits in the top bit, the answerer code in the low bits.
  for (genvar g = 0; g < NPLAYER; g++) begin : g_flag
    assign state_o[STATE_W-1-g] = lock[g];
  end
  assign state_o[ID_W-1:0] = turn;
endmodule

// File: rtl/quiz_arbiter_chk.sv
module quiz_arbiter_chk
  import quiz_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [ID_W-1:0]    buzz,
  input logic               wrong,
  input logic               correct,
  input logic [STATE_W-1:0] state_o,
  input logic [NPLAYER-1:0] lamp,
  input logic               ev_grant,
  input logic               ev_fault,
  input logic               ev_win
);
  pid_t   turn;
  pmask_t lockv;

  always_comb begin
    turn = state_o[ID_W-1:0];
    for (int i = 0; i < NPLAYER; i++) lockv[i] = state_o[STATE_W-1-i];
  end

  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> state_o == '0);

  a_r3_grant_loads: assert property (@(posedge clk) disable iff (rst)
    ev_grant |=> turn == $past(buzz));

  a_r3_turn_unbarred: assert property (@(posedge clk) disable iff (rst)
    (turn != NOBODY) |-> !is_barred(lockv, turn));

  a_r4_barred_hold: assert property (@(posedge clk) disable iff (rst)
    (turn == NOBODY && is_barred(lockv, buzz)) |=> $stable(state_o));

  a_r5_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (turn != NOBODY && !ev_fault && !ev_win) |=> $stable(state_o));

  a_r6_wrong_bars: assert property (@(posedge clk) disable iff (rst)
    (turn != NOBODY && wrong) |=> (turn == NOBODY) && is_barred(lockv, $past(turn)));

  a_r7_correct_clears: assert property (@(posedge clk) disable iff (rst)
    (turn != NOBODY && !wrong && correct) |=> state_o == '0);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (turn == NOBODY && !ev_grant) |=> $stable(state_o));

  a_r9_full_hold: assert property (@(posedge clk) disable iff (rst)
    (&lockv) |=> $stable(state_o));

  a_r10_lamp_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lamp) && ((turn == NOBODY) == (lamp == '0)));
endmodule

bind quiz_arbiter quiz_arbiter_chk u_chk (
  .clk(clk), .rst(rst), .buzz(buzz), .wrong(wrong), .correct(correct),
  .state_o(state_o), .lamp(lamp),
  .ev_grant(ev_grant), .ev_fault(ev_fault), .ev_win(ev_win)
);

// File: tb/quiz_arbiter_bench.sv
`timescale 1ns/1ps
module quiz_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] buzz = 2'd0;
  logic       wrong = 1'b0;
  logic       correct = 1'b0;
  logic [4:0] state_o;
  logic [2:0] lamp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [4:0] model = 5'd0;

  always #10 clk = ~clk;

  quiz_arbiter u_quiz_arbiter (
    .clk(clk), .rst(rst), .buzz(buzz), .wrong(wrong), .correct(correct),
    .state_o(state_o), .lamp(lamp)
  );

  // Expected next state from the requirements (bit 4 = contestant 1 flag).
  function automatic logic [4:0] ref_next(logic [4:0] s, logic r, logic [1:0] b,
                                          logic w, logic c);
    logic [4:0] n;
    n = s;
    if (r) return 5'd0;
    if (s[1:0] != 2'd0) begin
      if (w) begin
        case (s[1:0])
          2'd1: n[4] = 1'b1;
          2'd2: n[3] = 1'b1;
          default: n[2] = 1'b1;
        endcase
        n[1:0] = 2'd0;
      end else if (c) begin
        n = 5'd0;
      end
      return n;
    end
    case (b)
      2'd1: if (!s[4]) n[1:0] = 2'd1;
      2'd2: if (!s[3]) n[1:0] = 2'd2;
      2'd3: if (!s[2]) n[1:0] = 2'd3;
      default: ;
    endcase
    return n;
  endfunction

  function automatic logic [2:0] ref_lamp(logic [4:0] s);
    case (s[1:0])
      2'd1: return 3'b001;
      2'd2: return 3'b010;
      2'd3: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string rule_tag(logic [4:0] s, logic r, logic [1:0] b,
                                     logic w, logic c);
    if (r) return "R2";
    if (s[1:0] != 2'd0) return w ? "R6" : (c ? "R7" : "R5");
    if (s[4:2] == 3'b111) return "R9";
    if (b == 2'd0) return "R4";
    if ((b == 2'd1 && s[4]) || (b == 2'd2 && s[3]) || (b == 2'd3 && s[2])) return "R4";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Called just after a falling edge: drive, wait one cycle, compare.
  task automatic drive(logic r, logic [1:0] b, logic w, logic c, string tag);
    logic [4:0] exp;
    string t;
    t = (tag == "") ? rule_tag(model, r, b, w, c) : tag;
    rst = r; buzz = b; wrong = w; correct = c;
    exp = ref_next(model, r, b, w, c);
    @(negedge clk);
    chk(t, state_o, exp);
    chk("R10", {2'b00, lamp}, {2'b00, ref_lamp(exp)});
    model = exp;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h0051_2A7B));
    @(negedge clk);
    drive(1, 2'd0, 0, 0, "R2");
    drive(1, 2'd3, 1, 1, "R2");
    // R3 grant to contestant 1, R1 encoding 00001
    drive(0, 2'd1, 0, 0, "R3");
    chk("R1", state_o, 5'b00001);
    drive(0, 2'd2, 0, 0, "R5");
    drive(0, 2'd0, 1, 1, "R6");          // wrong beats correct -> 10000
    chk("R1", state_o, 5'b10000);
    drive(0, 2'd1, 0, 0, "R4");          // barred contestant refused
    drive(0, 2'd0, 1, 0, "R8");
    drive(0, 2'd0, 0, 1, "R8");
    drive(0, 2'd3, 0, 0, "R3");
    drive(0, 2'd0, 1, 0, "R6");
    drive(0, 2'd2, 0, 0, "R3");
    drive(0, 2'd0, 1, 0, "R6");          // all barred -> 11100
    chk("R1", state_o, 5'b11100);
    drive(0, 2'd1, 0, 0, "R9");
    drive(0, 2'd2, 1, 1, "R9");
    drive(0, 2'd3, 0, 1, "R9");
    drive(1, 2'd1, 1, 0, "R2");
    drive(0, 2'd2, 0, 0, "R3");
    drive(1, 2'd0, 1, 0, "R2");          // reset beats wrong
    drive(0, 2'd3, 0, 0, "R3");
    drive(0, 2'd1, 0, 1, "R7");
    for (int k = 0; k < 6000; k++) begin
      drive(($urandom % 60) == 0, 2'($urandom % 4),
            ($urandom % 3) == 0, ($urandom % 8) == 0, "");
    end
    finish_up();
  end
endmodule